// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is a single programmable logic cell. Five product-term inputs, chosen by a static mask, are ORed together with a cascade sum arriving from a neighbouring cell. The result is offered again on a cascade output so that cells can be chained into wide sums. The sum then passes through an XOR stage whose second operand is a constant or a product term. This gives polarity control for combinational use and operand folding for registered use.

One storage element follows the XOR stage. It can be configured as a D, T, JK or SR flip-flop, or as a latch. Its data input, clock source, clock enable, asynchronous clear and asynchronous preset are all selected by static configuration inputs. The cell output and the buried feedback each choose on their own between the combinational XOR result and the register view. The cell runs on a fast system clock `clk`. The cell clocks (three global clocks or a product term) are sampled on that clock, and the register acts on their rising edges. All configuration inputs are expected to be static while the cell is in use.

Product-term roles are fixed: pt_i[0] is the XOR operand, pt_i[1] is the dedicated data term and the second register input, pt_i[2] is the clock term and the clock enable, pt_i[3] is the clear term and pt_i[4] is the preset term.

Top module: `sop_cell`

## Requirements
- R1: While rst_n is low the register holds 0, so an output selecting the register view reads 0. A reset applied mid-run returns the register to 0.
- R2: casc_o equals the OR of casc_i and every pt_i[i] whose sum_mask_i[i] is 1.
- R3: The combinational result is casc_o XOR an operand. The operand is 0 for xor_sel_i=0, 1 for xor_sel_i=1, and pt_i[0] for xor_sel_i=2 or 3.
- R4: The register data input is the combinational result for din_sel_i=0, pt_i[1] for din_sel_i=1, and pin_i for din_sel_i=2 or 3.
- R5: ff_mode_i=0 (D) loads the data input and ff_mode_i=1 (T) inverts the state when the data input is 1. Both act once per rising edge of the selected cell clock, seen at the next clk edge.
- R6: ff_mode_i=2 (JK) uses the data input as J and pt_i[1] as K, and toggles when both are 1. ff_mode_i=3 (SR) uses the data input as S and pt_i[1] as R, and holds when both are 1.
- R7: ff_mode_i=4 (latch): while the selected clock is high, the register view follows the data input in the same cycle. While the clock is low, the view holds the last value passed.
- R8: clk_sel_i 0, 1 or 2 selects gclk_i[0], gclk_i[1] or gclk_i[2], and 3 selects pt_i[2]. Unselected clocks, and a selected clock that stays level, leave the state unchanged.
- R9: With ce_en_i=1 and a global clock selected, a rising edge while pt_i[2] is 0 is ignored, and a latch stays closed. With clk_sel_i=3, ce_en_i has no effect.
- R10: Clear is active from gclr_i when clr_sel_i[0]=1 and from pt_i[3] when clr_sel_i[1]=1. Preset is active from pt_i[4] when set_en_i=1. Each forces the register view in the same cycle and the state at the next clk edge.
- R11: When clear and preset are active together, clear wins and the register view reads 0.
- R12: out_reg_i=1 puts the register view on cell_o, and 0 puts the combinational result there. fb_reg_i selects in the same way for fb_o, independently of out_reg_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the cell clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_i | input | NUM_PT | Product-term inputs |
| casc_i | input | 1 | Cascade sum from the neighbouring cell |
| gclk_i | input | NUM_GCLK | Global cell clocks |
| gclr_i | input | 1 | Global clear |
| pin_i | input | 1 | Pin data |
| sum_mask_i | input | NUM_PT | Selects the terms that feed the OR |
| xor_sel_i | input | 2 | XOR operand select |
| din_sel_i | input | 2 | Register data select |
| ff_mode_i | input | 3 | Storage type |
| clk_sel_i | input | clog2(NUM_GCLK+1) | Cell clock select |
| ce_en_i | input | 1 | Use pt_i[2] as clock enable |
| clr_sel_i | input | 2 | Clear source select |
| set_en_i | input | 1 | Enable preset from pt_i[4] |
| out_reg_i | input | 1 | Cell output registered (1) or combinational (0) |
| fb_reg_i | input | 1 | Feedback registered (1) or combinational (0) |
| casc_o | output | 1 | Combined sum for the next cell |
| cell_o | output | 1 | Cell output |
| fb_o | output | 1 | Buried feedback |

## Verification
Clear and preset can be active in the same cycle. A clock-enable low can also coincide with a rising edge of the selected clock. Both collisions are provoked by driving pt_i[2], pt_i[3], pt_i[4] and gclr_i from biased random streams, at high rates in the dedicated sections and across every combination of mode, clock select, enable and clear source in the sweep. Each cycle, a bench model built from the requirements gives the expected cell_o, fb_o and casc_o. Properties also check that a collision always resolves to 0 and that a gated edge leaves the state untouched.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;

  // fixed product-term roles
  localparam int PT_XOR  = 0;
  localparam int PT_DATA = 1;
  localparam int PT_CLK  = 2;
  localparam int PT_CLR  = 3;
  localparam int PT_SET  = 4;
  localparam int MIN_PT  = 5;

  typedef enum logic [2:0] {
    FF_D     = 3'd0,
    FF_T     = 3'd1,
    FF_JK    = 3'd2,
    FF_SR    = 3'd3,
    FF_LATCH = 3'd4
  } ff_mode_e;

  // next state of an edge-triggered element; a = D/T/J/S, b = K/R
  function automatic logic ff_next(ff_mode_e m, logic q, logic a, logic b);
    case (m)
      FF_T:  return q ^ a;
      FF_JK: return (a & ~q) | (~b & q);
      FF_SR: begin
        if (a && !b)      return 1'b1;
        else if (b && !a) return 1'b0;
        else              return q;
      end
      default: return a;
    endcase
  endfunction

endpackage

// File: rtl/sop_sum_stage.sv
module sop_sum_stage #(
  parameter int NUM_PT = 5
) (
  input  logic [NUM_PT-1:0] pt_i,
  input  logic [NUM_PT-1:0] mask_i,
  input  logic              casc_i,
  input  logic              xor_pt_i,
  input  logic [1:0]        xor_sel_i,
  output logic              sum_o,
  output logic              xor_o
);

  logic [NUM_PT-1:0] term_on;
  logic              operand;

  for (genvar g = 0; g < NUM_PT; g++) begin : g_term
    assign term_on[g] = pt_i[g] & mask_i[g];
  end

  assign sum_o = (|term_on) | casc_i;

  always_comb begin
    case (xor_sel_i)
      2'd0:    operand = 1'b0;
      2'd1:    operand = 1'b1;
      default: operand = xor_pt_i;
    endcase
  end

  assign xor_o = sum_o ^ operand;

endmodule

// File: rtl/sop_clk_ctl.sv
module sop_clk_ctl #(
  parameter int NUM_GCLK = 3,
  localparam int SEL_W   = $clog2(NUM_GCLK + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                pt_ctl_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                ce_en_i,
  output logic                level_o,
  output logic                rise_o,
  output logic                gate_o
);

  logic use_global;
  logic level_q;

  always_comb begin
    level_o    = pt_ctl_i;
    use_global = 1'b0;
    for (int i = 0; i < NUM_GCLK; i++) begin
      if (sel_i == SEL_W'(i)) begin
        level_o    = gclk_i[i];
        use_global = 1'b1;
      end
    end
  end

  // enable only honoured on a global clock
  assign gate_o = !(ce_en_i && use_global) || pt_ctl_i;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_o;
  end

  assign rise_o = level_o & ~level_q;

endmodule

// File: rtl/sop_storage.sv
module sop_storage
  import sop_cell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       d_i,
  input  logic       k_i,
  input  logic       level_i,
  input  logic       fire_i,
  input  logic       gate_i,
  input  logic       clr_i,
  input  logic       set_i,
  output logic       q_o,
  output logic       view_o,
  output logic       open_o
);

  ff_mode_e mode;
  logic     is_latch;
  logic     q_nxt;

  assign mode     = ff_mode_e'(mode_i);
  assign is_latch = (mode == FF_LATCH);
  assign open_o   = is_latch & level_i & gate_i;

  always_comb begin
    if (clr_i)         q_nxt = 1'b0;
    else if (set_i)    q_nxt = 1'b1;
    else if (is_latch) q_nxt = open_o ? d_i : q_o;
    else if (fire_i)   q_nxt = ff_next(mode, q_o, d_i, k_i);
    else               q_nxt = q_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_nxt;
  end

  // clear and preset act on the view at once, clear first
  always_comb begin
    if (clr_i)       view_o = 1'b0;
    else if (set_i)  view_o = 1'b1;
    else if (open_o) view_o = d_i;
    else             view_o = q_o;
  end

endmodule

// File: rtl/sop_cell.sv
module sop_cell
  import sop_cell_pkg::*;
#(
  parameter int NUM_PT   = 5,
  parameter int NUM_GCLK = 3,
  localparam int CSEL_W  = $clog2(NUM_GCLK + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PT-1:0]   pt_i,
  input  logic                casc_i,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                gclr_i,
  input  logic                pin_i,
  input  logic [NUM_PT-1:0]   sum_mask_i,
  input  logic [1:0]          xor_sel_i,
  input  logic [1:0]          din_sel_i,
  input  logic [2:0]          ff_mode_i,
  input  logic [CSEL_W-1:0]   clk_sel_i,
  input  logic                ce_en_i,
  input  logic [1:0]          clr_sel_i,
  input  logic                set_en_i,
  input  logic                out_reg_i,
  input  logic                fb_reg_i,
  output logic                casc_o,
  output logic                cell_o,
  output logic                fb_o
);

  if (NUM_PT < MIN_PT) begin : g_bad_pt
    $error("sop_cell needs at least five product terms");
  end

  logic sum_w, xor_w, d_w;
  logic src_level, src_rise, clk_gate, fire_w;
  logic clr_act, set_act;
  logic q_state, reg_view, latch_open;

  sop_sum_stage #(.NUM_PT(NUM_PT)) u_sum (
    .pt_i      (pt_i),
    .mask_i    (sum_mask_i),
    .casc_i    (casc_i),
    .xor_pt_i  (pt_i[PT_XOR]),
    .xor_sel_i (xor_sel_i),
    .sum_o     (sum_w),
    .xor_o     (xor_w)
  );

  assign casc_o = sum_w;

  always_comb begin
    case (din_sel_i)
      2'd0:    d_w = xor_w;
      2'd1:    d_w = pt_i[PT_DATA];
      default: d_w = pin_i;
    endcase
  end

  sop_clk_ctl #(.NUM_GCLK(NUM_GCLK)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gclk_i   (gclk_i),
    .pt_ctl_i (pt_i[PT_CLK]),
    .sel_i    (clk_sel_i),
    .ce_en_i  (ce_en_i),
    .level_o  (src_level),
    .rise_o   (src_rise),
    .gate_o   (clk_gate)
  );

  assign fire_w = src_rise & clk_gate;

  always_comb begin
    case (clr_sel_i)
      2'b01:   clr_act = gclr_i;
      2'b10:   clr_act = pt_i[PT_CLR];
      2'b11:   clr_act = gclr_i | pt_i[PT_CLR];
      default: clr_act = 1'b0;
    endcase
  end

  assign set_act = set_en_i & pt_i[PT_SET];

  sop_storage u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (ff_mode_i),
    .d_i     (d_w),
    .k_i     (pt_i[PT_DATA]),
    .level_i (src_level),
    .fire_i  (fire_w),
    .gate_i  (clk_gate),
    .clr_i   (clr_act),
    .set_i   (set_act),
    .q_o     (q_state),
    .view_o  (reg_view),
    .open_o  (latch_open)
  );

  assign cell_o = out_reg_i ? reg_view : xor_w;
  assign fb_o   = fb_reg_i  ? reg_view : xor_w;

endmodule

// File: rtl/sop_cell_chk.sv
module sop_cell_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       casc_i,
  input logic       casc_o,
  input logic [2:0] mode_i,
  input logic       src_rise,
  input logic       clk_gate,
  input logic       clr_act,
  input logic       set_act,
  input logic       latch_open,
  input logic       d_w,
  input logic       k_in,
  input logic       q_state,
  input logic       reg_view,
  input logic       fb_reg_i,
  input logic       fb_o
);

  logic edge_mode;
  assign edge_mode = (mode_i != 3'd4);

  assert_casc_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    casc_i |-> casc_o);

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |-> !reg_view);

  assert_clear_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> !q_state);

  assert_preset_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_act && !clr_act) |=> q_state);

  assert_gated_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rise && !clk_gate && !clr_act && !set_act && edge_mode) |=> $stable(q_state));

  assert_no_rise_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_rise && !clr_act && !set_act && edge_mode) |=> $stable(q_state));

  assert_jk_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd2 && src_rise && clk_gate && !clr_act && !set_act && d_w && k_in)
      |=> (q_state != $past(q_state)));

  assert_latch_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_open && !clr_act && !set_act) |-> (reg_view == d_w));

  assert_fb_reg_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fb_reg_i |-> (fb_o == reg_view));

endmodule

bind sop_cell sop_cell_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .casc_i     (casc_i),
  .casc_o     (casc_o),
  .mode_i     (ff_mode_i),
  .src_rise   (src_rise),
  .clk_gate   (clk_gate),
  .clr_act    (clr_act),
  .set_act    (set_act),
  .latch_open (latch_open),
  .d_w        (d_w),
  .k_in       (pt_i[1]),
  .q_state    (q_state),
  .reg_view   (reg_view),
  .fb_reg_i   (fb_reg_i),
  .fb_o       (fb_o)
);

// File: tb/sop_cell_test.sv
`timescale 1ns/1ps
module sop_cell_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] pt = '0;
  logic       casc = 1'b0, gclr = 1'b0, pin = 1'b0;
  logic [2:0] gclk = '0;
  logic [4:0] mask = '0;
  logic [1:0] xsel = '0, dsel = '0, csel = '0, asel = '0;
  logic [2:0] mode = '0;
  logic       ce = 1'b0, apen = 1'b0, oreg = 1'b0, freg = 1'b0;
  logic       casc_o, cell_o, fb_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;
  logic m_q = 1'b0, m_prev = 1'b0;

  always #4 clk = ~clk;

  sop_cell uut (
    .clk(clk), .rst_n(rst_n), .pt_i(pt), .casc_i(casc), .gclk_i(gclk),
    .gclr_i(gclr), .pin_i(pin), .sum_mask_i(mask), .xor_sel_i(xsel),
    .din_sel_i(dsel), .ff_mode_i(mode), .clk_sel_i(csel), .ce_en_i(ce),
    .clr_sel_i(asel), .set_en_i(apen), .out_reg_i(oreg), .fb_reg_i(freg),
    .casc_o(casc_o), .cell_o(cell_o), .fb_o(fb_o)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (mode %0d csel %0d ce %b asel %0d)",
               tag, what, act, exp, mode, csel, ce, asel);
    end
  endtask

  // inputs are set at a falling edge before the call
  task automatic step(string tag);
    logic s, op, x, d, src, gate, ar, ap, lat, view, nq;
    #1;
    s    = (|(pt & mask)) | casc;
    op   = xsel[1] ? pt[0] : xsel[0];
    x    = s ^ op;
    d    = (dsel == 2'd0) ? x : (dsel == 2'd1) ? pt[1] : pin;
    src  = (csel == 2'd3) ? pt[2] : gclk[csel];
    gate = !(ce && csel != 2'd3) || pt[2];
    ar   = (asel[0] && gclr) || (asel[1] && pt[3]);
    ap   = apen && pt[4];
    lat  = (mode == 3'd4);
    view = ar ? 1'b0 : ap ? 1'b1 : (lat && src && gate) ? d : m_q;
    check(tag, "casc_o", casc_o, s);
    check(tag, "cell_o", cell_o, oreg ? view : x);
    check(tag, "fb_o",   fb_o,   freg ? view : x);
    @(posedge clk);
    if (ar)       nq = 1'b0;
    else if (ap)  nq = 1'b1;
    else if (lat) nq = (src && gate) ? d : m_q;
    else if (src && !m_prev && gate) begin
      case (mode)
        3'd1:    nq = m_q ^ d;
        3'd2:    nq = d ? (pt[1] ? ~m_q : 1'b1) : (pt[1] ? 1'b0 : m_q);
        3'd3:    nq = (d && !pt[1]) ? 1'b1 : (pt[1] && !d) ? 1'b0 : m_q;
        default: nq = d;
      endcase
    end else nq = m_q;
    m_q    = nq;
    m_prev = src;
    @(negedge clk);
  endtask

  // random stimulus; clear/preset sources fire about 1 in rate steps
  task automatic run(string tag, int n, int rate);
    for (int i = 0; i < n; i++) begin
      pt    = 5'($urandom);
      pt[3] = (($urandom % rate) == 0);
      pt[4] = (($urandom % rate) == 0);
      gclr  = (($urandom % rate) == 0);
      casc  = 1'($urandom);
      pin   = 1'($urandom);
      gclk  = 3'($urandom);
      step(tag);
    end
  endtask

  task automatic defaults();
    mask = '0; xsel = 2'd0; dsel = 2'd1; mode = 3'd0; csel = 2'd0;
    ce = 1'b0; asel = 2'd0; apen = 1'b0; oreg = 1'b1; freg = 1'b0;
  endtask

  task automatic zero_inputs();
    pt = '0; casc = 1'b0; gclr = 1'b0; pin = 1'b0; gclk = '0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    defaults();
    oreg = 1'b1; freg = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "cell_o in reset", cell_o, 1'b0);
    check("R1", "fb_o in reset",   fb_o,   1'b0);
    rst_n = 1'b1;
    m_q = 1'b0; m_prev = 1'b0;

    // R2: sum with cascade, two masks, every term pattern
    defaults(); oreg = 1'b0;
    foreach (mask_list[k]) begin
      mask = mask_list[k];
      for (int p = 0; p < 32; p++)
        for (int c = 0; c < 2; c++) begin
          pt = 5'(p); casc = 1'(c); step("R2");
        end
    end
    casc = 1'b0;

    // R3: every operand choice
    mask = 5'b00110;
    for (int xs = 0; xs < 4; xs++) begin
      xsel = 2'(xs);
      for (int p = 0; p < 32; p++) begin pt = 5'(p); step("R3"); end
    end

    // R4: data source choice
    defaults(); mask = 5'b01101; xsel = 2'd2;
    for (int ds = 0; ds < 4; ds++) begin dsel = 2'(ds); run("R4", 24, 1000); end

    // R5: D and T
    defaults();
    for (int m = 0; m < 2; m++) begin
      mode = 3'(m);
      for (int ds = 0; ds < 3; ds++) begin dsel = 2'(ds); run("R5", 20, 1000); end
    end

    // R6: JK and SR
    for (int m = 2; m < 4; m++) begin
      mode = 3'(m); dsel = 2'd2; run("R6", 60, 1000);
      dsel = 2'd1; run("R6", 20, 1000);
    end

    // R7: latch on a global clock and on the term clock
    mode = 3'd4; dsel = 2'd2;
    for (int cs = 0; cs < 4; cs += 3) begin csel = 2'(cs); run("R7", 40, 1000); end

    // R8: every clock choice
    mode = 3'd1; dsel = 2'd2; pin = 1'b1;
    for (int cs = 0; cs < 4; cs++) begin csel = 2'(cs); run("R8", 30, 1000); end

    // R9: clock enable, global and term clock
    ce = 1'b1;
    for (int m = 0; m < 5; m += 4) begin
      mode = 3'(m);
      for (int cs = 0; cs < 4; cs++) begin csel = 2'(cs); run("R9", 30, 1000); end
    end

    // R10: clear sources and preset
    defaults(); mode = 3'd1; dsel = 2'd2;
    for (int a = 0; a < 4; a++)
      for (int e = 0; e < 2; e++) begin
        asel = 2'(a); apen = 1'(e); run("R10", 30, 2);
      end

    // R11: clear and preset colliding
    asel = 2'd3; apen = 1'b1;
    run("R11", 40, 2);
    zero_inputs(); gclr = 1'b1; pt[4] = 1'b1; step("R11");

    // R12: output and feedback chosen independently
    defaults(); mode = 3'd1; dsel = 2'd2; mask = 5'b11111;
    for (int o = 0; o < 4; o++) begin
      oreg = o[0]; freg = o[1]; run("R12", 20, 1000);
    end

    // near-exhaustive sweep over the control configuration
    defaults(); mask = 5'b10011; oreg = 1'b1; freg = 1'b0;
    for (int m = 0; m < 5; m++)
      for (int cs = 0; cs < 4; cs++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 4; a++)
            for (int e = 0; e < 2; e++)
              for (int ds = 0; ds < 3; ds++) begin
                mode = 3'(m); csel = 2'(cs); ce = 1'(c); asel = 2'(a);
                apen = 1'(e); dsel = 2'(ds); xsel = 2'($urandom);
                oreg = ~oreg; freg = ~oreg;
                run("R5", 8, 6);
              end

    // R1: reset from a set register
    defaults(); zero_inputs(); apen = 1'b1; pt[4] = 1'b1; step("R10");
    pt[4] = 1'b0; step("R10");
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1", "cell_o after mid-run reset", cell_o, 1'b0);
    rst_n = 1'b1;
    m_q = 1'b0; m_prev = 1'b0;
    step("R1");

    done = 1;
    summary();
    $finish;
  end

  logic [4:0] mask_list [2] = '{5'b10110, 5'b01001};

endmodule